// File: doc/BRIEF.md
# Dual-Role SPI Shift Unit

This block moves one byte at a time over a four-wire-style serial link. It acts as either the clocking side or the clocked side of the link, picked by a role bit. A second mode bit parks the unit for a two-wire bus that is handled elsewhere. Both roles share one eight-bit shift register. It is loaded in parallel, shifts out most significant bit first, and the received byte is read back in parallel once the transfer completes.

In the clocking role, the unit makes its serial clock from the system clock. A programmable half-period sets the rate, and the clock pin is flagged as driven. In the clocked role, the incoming serial clock and data pass through a flop synchroniser. Edges are detected in the system clock domain, and the unit only reacts to them after software has armed it with a load. Two controls set the link mode. Polarity sets the idle level of the clock, and phase picks which clock edge moves the output and which captures the input. A separate enable gates the serial data output.

Top module: `spi_shift_unit`

## Requirements
- R1: With `cfg_i2c`=0, `cfg_master`=1 selects the clocking role (`sclk_oe`=1) and `cfg_master`=0 the clocked role (`sclk_oe`=0). With `cfg_i2c`=1 the unit is parked: `sclk_oe`=0, `sdo_oe`=0, and a load is ignored (busy stays 0, `rd_data` and `done` are unchanged).
- R2: In the clocking role, whenever no transfer runs, `sclk_out` equals `cfg_cpol`, and it is back at that level after the last edge of a transfer.
- R3: A leading edge is one that leaves the idle level. With `cfg_cpha`=0 the input is captured on leading edges and the output moves on trailing edges. With `cfg_cpha`=1 the output moves on every leading edge except the first, and the input is captured on trailing edges.
- R4: After an accepted load, `sdo` shows bit 7 of the loaded byte before any clock edge, in both phase settings.
- R5: `sdo_oe` = `cfg_oe` while not parked. When it is 0, `sdo` is held at 0.
- R6: A transfer is 8 bits. `sdo` presents the loaded bits 7 down to 0 in order, and the first bit captured lands in bit 7 of `rd_data`.
- R7: `done` clears on an accepted load and sets after the eighth capture edge. `rd_data` then holds the received byte, and both hold until the next accepted load.
- R8: In the clocking role, each clock half-period lasts `cfg_half_div` system cycles, with 0 treated as 1. The first edge comes that many cycles after the load is accepted, and exactly 16 edges are produced.
- R9: In the clocked role, clock and data pass through a two-flop synchroniser. Edges seen while the unit is not armed by a load leave `rd_data`, `done` and `sdo` unchanged.
- R10: A load presented while `busy`=1 is ignored and does not disturb the running transfer.
- R11: `busy` is 1 from an accepted load until the last clock edge in the clocking role, or until the eighth capture in the clocked role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = clocking role, 0 = clocked role |
| cfg_i2c | input | 1 | 1 = unit parked for a two-wire bus |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Edge assignment for output and capture |
| cfg_oe | input | 1 | Serial data output enable |
| cfg_half_div | input | DIV_W | Clock half-period in system cycles (clocking role) |
| ld_valid | input | 1 | Parallel load strobe, starts or arms a transfer |
| ld_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| done | output | 1 | Transfer complete flag |
| busy | output | 1 | Transfer in progress |
| sclk_in | input | 1 | External serial clock (clocked role) |
| sclk_out | output | 1 | Generated serial clock (clocking role) |
| sclk_oe | output | 1 | Serial clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out drive enable |

## Verification
Every polarity and phase pair is run in the clocking role. Each pair is tried with half-periods of 0 to 3 and several distinct transmit and receive bytes. A bench-side peer shifts its byte on the edges R3 assigns and records the unit's output on the opposite edges. A wrong edge choice, a wrong bit order or a miscounted divider therefore shows up as a wrong byte or a wrong gap. The same four mode pairs are then driven from the bench as the clocking side, at a rate slow enough for the synchroniser. After that, stray clock edges are sent to an idle unit, a load is injected mid-transfer, the unit is parked, and the output enable is toggled. Each of these stimuli targets one requirement and shows whether the unit ignores what it should.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    // One serial clock event, as seen by the shift core
    typedef struct packed {
        logic lead;   // edge leaving the idle level
        logic trail;  // edge returning to the idle level
    } sclk_evt_t;

endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_shift_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cpol_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_o,
    output sclk_evt_t        evt_o,
    output logic             running_o
);

    localparam int EDGES = 2 * BITS;
    localparam int TCW   = $clog2(EDGES + 1);

    typedef struct packed {
        logic             running;
        logic             sclk;
        logic [DIV_W-1:0] div_cnt;
        logic [TCW-1:0]   tog_cnt;
    } gen_st_t;

    gen_st_t          q, d;
    logic [DIV_W-1:0] half_m1;
    sclk_evt_t        evt;

    always_comb begin
        half_m1 = (div_i == '0) ? '0 : (div_i - DIV_W'(1));
        d       = q;
        evt     = '0;
        if (start_i) begin
            d.running = 1'b1;
            d.sclk    = cpol_i;
            d.div_cnt = '0;
            d.tog_cnt = '0;
        end else if (q.running) begin
            if (q.div_cnt == half_m1) begin
                d.div_cnt = '0;
                d.sclk    = ~q.sclk;
                if (q.sclk == cpol_i) evt.lead = 1'b1;
                else                  evt.trail = 1'b1;
                d.tog_cnt = q.tog_cnt + TCW'(1);
                if (q.tog_cnt == TCW'(EDGES - 1)) d.running = 1'b0;
            end else begin
                d.div_cnt = q.div_cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o    = q.running ? q.sclk : cpol_i;
    assign evt_o     = evt;
    assign running_o = q.running;

    // R2: the clock is back at its idle level when a run ends
    assert_idle_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.running) |-> (q.sclk == cpol_i));

    // R8: never more than the edge budget of one transfer
    assert_edge_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.tog_cnt <= TCW'(EDGES));

    // R8: the divider count stays inside the half-period
    assert_div_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.running |-> (q.div_cnt <= half_m1));

endmodule

// File: rtl/spi_sclk_sync.sv
module spi_sclk_sync
    import spi_shift_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_i,
    input  logic      sdi_i,
    input  logic      cpol_i,
    output sclk_evt_t evt_o,
    output logic      sdi_o
);

    localparam int CLEN = STAGES + 1;

    typedef struct packed {
        logic [CLEN-1:0]   clk_sh;
        logic [STAGES-1:0] dat_sh;
    } sync_st_t;

    sync_st_t q, d;
    logic     cur, prev, rise, fall;

    always_comb begin
        d.clk_sh = (q.clk_sh << 1) | CLEN'(sclk_i);
        d.dat_sh = (q.dat_sh << 1) | STAGES'(sdi_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        cur        = q.clk_sh[STAGES-1];
        prev       = q.clk_sh[STAGES];
        rise       = cur & ~prev;
        fall       = ~cur & prev;
        evt_o.lead  = cpol_i ? fall : rise;
        evt_o.trail = cpol_i ? rise : fall;
    end

    assign sdi_o = q.dat_sh[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_shift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         cpha_i,
    input  sclk_evt_t    evt_i,
    input  logic         sdi_i,
    output logic         sr_msb_o,
    output logic [W-1:0] rx_o,
    output logic         done_o,
    output logic         active_o
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic          smp;
        logic [CW-1:0] cnt;
        logic          active;
        logic          done;
        logic [W-1:0]  rx;
    } core_st_t;

    core_st_t q, d;
    logic     sample_ev, update_ev;

    always_comb begin
        sample_ev = cpha_i ? evt_i.trail : evt_i.lead;
        update_ev = cpha_i ? evt_i.lead  : evt_i.trail;
        d         = q;
        if (load_i) begin
            d.sr     = data_i;
            d.cnt    = '0;
            d.active = 1'b1;
            d.done   = 1'b0;
        end else if (q.active) begin
            // no shift before the first capture: the MSB stays on the line
            if (update_ev && (q.cnt != '0)) d.sr = {q.sr[W-2:0], q.smp};
            if (sample_ev) begin
                d.smp = sdi_i;
                d.cnt = q.cnt + CW'(1);
                if (q.cnt == CW'(W - 1)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                    d.rx     = {q.sr[W-2:0], sdi_i};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sr_msb_o = q.sr[W-1];
    assign rx_o     = q.rx;
    assign done_o   = q.done;
    assign active_o = q.active;

    // R7: completion only after the full bit count
    assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> (q.cnt == CW'(W)));

    // R10: the top never hands over a load while a transfer is armed
    assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !q.active);

    // R4: the loaded MSB is on the output the cycle after the load
    assert_msb_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sr_msb_o == $past(data_i[W-1])));

    // R9: an unarmed unit keeps its shift register and result
    assert_frozen_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && !load_i) |=> ($stable(q.sr) && $stable(q.rx)));

    // R3: the event source never reports two edges at once
    assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_i.lead, evt_i.trail}));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
    import spi_shift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_i2c,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_oe,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);

    logic      enabled, is_master, load_ok;
    logic      gen_running, core_active, sr_msb, sync_sdi, core_sdi;
    sclk_evt_t gen_evt, sync_evt, core_evt;

    assign enabled   = ~cfg_i2c;
    assign is_master = cfg_master & enabled;
    assign busy      = core_active | gen_running;
    assign load_ok   = ld_valid & enabled & ~busy;

    spi_sclk_gen #(.DIV_W(DIV_W), .BITS(DATA_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (load_ok & is_master),
        .cpol_i    (cfg_cpol),
        .div_i     (cfg_half_div),
        .sclk_o    (sclk_out),
        .evt_o     (gen_evt),
        .running_o (gen_running)
    );

    spi_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_in),
        .sdi_i  (sdi),
        .cpol_i (cfg_cpol),
        .evt_o  (sync_evt),
        .sdi_o  (sync_sdi)
    );

    assign core_evt = is_master ? gen_evt : sync_evt;
    assign core_sdi = is_master ? sdi     : sync_sdi;

    spi_shift_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_ok),
        .data_i   (ld_data),
        .cpha_i   (cfg_cpha),
        .evt_i    (core_evt),
        .sdi_i    (core_sdi),
        .sr_msb_o (sr_msb),
        .rx_o     (rd_data),
        .done_o   (done),
        .active_o (core_active)
    );

    assign sclk_oe = is_master;
    assign sdo_oe  = cfg_oe & enabled;
    assign sdo     = (cfg_oe & enabled) ? sr_msb : 1'b0;

    // R1: a parked unit drives neither pin
    assert_parked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i2c |-> (!sclk_oe && !sdo_oe));

    // R1: a parked unit never starts a transfer
    assert_parked_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i2c && !busy) |=> !busy);

endmodule

// File: tb/spi_shift_unit_test.sv
module spi_shift_unit_test;

    localparam int W  = 8;
    localparam int DW = 8;
    localparam int HS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_master, cfg_i2c, cfg_cpol, cfg_cpha, cfg_oe;
    logic [DW-1:0] cfg_half_div;
    logic          ld_valid;
    logic [W-1:0]  ld_data, rd_data;
    logic          done, busy, sclk_in, sclk_out, sclk_oe, sdi, sdo, sdo_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_shift_unit #(.DATA_W(W), .DIV_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_i2c(cfg_i2c),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_oe(cfg_oe),
        .cfg_half_div(cfg_half_div), .ld_valid(ld_valid), .ld_data(ld_data),
        .rd_data(rd_data), .done(done), .busy(busy), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    function automatic logic [7:0] pat(input int k, input int salt);
        return 8'(k * 37 + salt * 91) ^ 8'hA5;
    endfunction

    task automatic run_master(input logic cpol, input logic cpha, input logic [DW-1:0] div,
                              input logic [7:0] tx, input logic [7:0] slv, input bit intrude);
        int half, gap, edges, nl, nt, guard;
        logic prev;
        logic [7:0] got;
        half = (div == 0) ? 1 : int'(div);
        cfg_master = 1'b1; cfg_i2c = 1'b0; cfg_oe = 1'b1;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_half_div = div;
        sdi = cpha ? 1'b0 : slv[7];
        @(negedge clk); ld_valid = 1'b1; ld_data = tx;
        @(negedge clk); ld_valid = 1'b0;
        chk("R4", "msb after load", sdo, tx[7]);
        chk("R11", "busy after load", busy, 1);
        chk("R7", "done cleared by load", done, 0);
        prev = sclk_out; gap = 0; edges = 0; nl = 0; nt = 0; guard = 0; got = '0;
        while (edges < 16 && guard < 2000) begin
            @(negedge clk);
            guard++; gap++;
            if (ld_valid) ld_valid = 1'b0;
            if (sclk_out !== prev) begin
                edges++;
                chk("R8", "half period", gap, half);
                gap = 0;
                if (prev == cpol) begin
                    if (!cpha) got = {got[6:0], sdo};
                    else       sdi = slv[7-nl];
                    nl++;
                    if (intrude && nl == 4) begin ld_valid = 1'b1; ld_data = ~tx; end
                end else begin
                    if (cpha)        got = {got[6:0], sdo};
                    else if (nt < 7) sdi = slv[6-nt];
                    nt++;
                end
                prev = sclk_out;
            end
        end
        @(negedge clk);
        chk("R8", "edge count", edges, 16);
        chk("R2", "idle after transfer", sclk_out, cpol);
        chk("R11", "busy after transfer", busy, 0);
        chk("R7", "done after transfer", done, 1);
        chk("R6", "received byte", rd_data, slv);
        chk(intrude ? "R10" : "R3", "bits seen on sdo", got, tx);
        chk("R1", "clock pin driven", sclk_oe, 1);
    endtask

    task automatic run_slave(input logic cpol, input logic cpha,
                             input logic [7:0] tx, input logic [7:0] mst);
        logic [7:0] got;
        got = '0;
        cfg_master = 1'b0; cfg_i2c = 1'b0; cfg_oe = 1'b1;
        cfg_cpol = cpol; cfg_cpha = cpha;
        sclk_in = cpol; sdi = cpha ? 1'b0 : mst[7];
        repeat (6) @(negedge clk);
        ld_valid = 1'b1; ld_data = tx;
        @(negedge clk); ld_valid = 1'b0;
        chk("R4", "slave msb after load", sdo, tx[7]);
        chk("R1", "clock pin input", sclk_oe, 0);
        chk("R11", "slave busy", busy, 1);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_in = ~cpol;
            if (!cpha) got = {got[6:0], sdo};
            else       sdi = mst[7-i];
            repeat (HS) @(negedge clk);
            sclk_in = cpol;
            if (cpha)       got = {got[6:0], sdo};
            else if (i < 7) sdi = mst[6-i];
            repeat (HS) @(negedge clk);
        end
        chk("R7", "slave done", done, 1);
        chk("R6", "slave received byte", rd_data, mst);
        chk("R3", "slave bits on sdo", got, tx);
        chk("R11", "slave busy end", busy, 0);
    endtask

    initial begin
        logic [7:0] keep_rd;
        logic       keep_sdo;
        cfg_master = 1'b1; cfg_i2c = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        cfg_oe = 1'b1; cfg_half_div = '0; ld_valid = 1'b0; ld_data = '0;
        sclk_in = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset done", done, 0);
        chk("R11", "reset busy", busy, 0);
        chk("R6", "reset rd_data", rd_data, 0);
        chk("R1", "reset role", sclk_oe, 1);

        // R2: idle level follows polarity
        cfg_cpol = 1'b1; @(negedge clk);
        chk("R2", "idle high", sclk_out, 1);
        cfg_cpol = 1'b0; @(negedge clk);
        chk("R2", "idle low", sclk_out, 0);

        // clocking role sweep: every mode, divider 0..3, several bytes
        for (int m = 0; m < 4; m++)
            for (int dv = 0; dv < 4; dv++)
                for (int k = 0; k < 6; k++)
                    run_master(m[1], m[0], DW'(dv), pat(k, m + dv), ~pat(k + 3, m), 1'b0);

        // R10: a load injected mid-transfer
        run_master(1'b0, 1'b0, DW'(2), 8'h3C, 8'hD2, 1'b1);
        run_master(1'b1, 1'b1, DW'(1), 8'h81, 8'h7E, 1'b1);

        // clocked role sweep
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 8; k++)
                run_slave(m[1], m[0], pat(k, m), pat(k + 5, m + 2));

        // R9: stray edges on an unarmed unit
        keep_rd = rd_data; keep_sdo = sdo;
        for (int i = 0; i < 10; i++) begin
            sclk_in = ~sclk_in; sdi = i[0];
            repeat (HS) @(negedge clk);
        end
        chk("R9", "stray edges rd_data", rd_data, keep_rd);
        chk("R9", "stray edges done", done, 1);
        chk("R9", "stray edges sdo", sdo, keep_sdo);
        chk("R9", "stray edges busy", busy, 0);

        // R1: parked unit ignores a load
        cfg_i2c = 1'b1; cfg_master = 1'b1;
        @(negedge clk);
        chk("R1", "parked clock pin", sclk_oe, 0);
        chk("R1", "parked data pin", sdo_oe, 0);
        ld_valid = 1'b1; ld_data = 8'h5A;
        @(negedge clk); ld_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "parked busy", busy, 0);
        chk("R1", "parked done", done, 1);
        chk("R1", "parked rd_data", rd_data, keep_rd);
        cfg_i2c = 1'b0;

        // R5: output enable gating
        cfg_master = 1'b0; cfg_oe = 1'b1;
        repeat (2) @(negedge clk);
        ld_valid = 1'b1; ld_data = 8'hFF;
        @(negedge clk); ld_valid = 1'b0;
        chk("R5", "enabled sdo", sdo, 1);
        chk("R5", "enabled sdo_oe", sdo_oe, 1);
        cfg_oe = 1'b0; @(negedge clk);
        chk("R5", "disabled sdo", sdo, 0);
        chk("R5", "disabled sdo_oe", sdo_oe, 0);
        cfg_oe = 1'b1; @(negedge clk);
        chk("R5", "re-enabled sdo", sdo, 1);

        finish_run();
    end

endmodule